// File: doc/BRIEF.md
# Butterfly Accumulate-and-Round Stage

This block finishes a two-coefficient butterfly on signed integers. A preceding twin step, run without any shift, leaves two unshifted accumulators in the form a*c1 + b*c1 and a*c1 - b*c1. This stage takes those two accumulators, the operand b, and the coefficient difference d = c2 - c1. It forms one double-width product b*d. It adds that product to the plus-lane accumulator and subtracts it from the minus-lane accumulator. Both sums are then rounded and shifted right by a common amount. Because the single shift comes after accumulation, the outputs equal round(a*c1 + b*c2) and round(a*c1 - b*c2). No precision is lost in between.

Both accumulators are sign-extended before the add or subtract. The arithmetic runs in a width one bit wider than twice the data width, so neither the product nor the rounding term can wrap. The shift amount ranges from 0 to 2*XLEN-1, and XLEN must be a power of two. Both results are captured on an input valid strobe and appear one clock later.

Top module: `bfly_mac_rs`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `res_p` and `res_m` become 0 after that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising clock edge.
- R3: For a strobe with inputs (A, B, D, S), `res_p` becomes the low XLEN bits of floor((A + B*D + R) / 2^S). All operands are signed two's complement, R is 2^(S-1) when S > 0 and 0 when S = 0, and the arithmetic is exact.
- R4: For the same strobe, `res_m` becomes the low XLEN bits of floor((M - B*D + R) / 2^S), where M is the minus-lane accumulator.
- R5: With a shift of 0, no rounding term is added, and each result is the low XLEN bits of the accumulator plus or minus the product.
- R6: An exact half rounds toward plus infinity: 3 with shift 1 yields 2, and -3 with shift 1 yields -1.
- R7: Result bits whose source position lies above the extended sum are filled with its sign. With XLEN = 32, shift 40, accumulators 0 and product 0x80000000 * 0x7FFFFFFF, the results are 0xFFC00000 (plus lane) and 0x00400000 (minus lane).
- R8: When `in_valid` is low at a rising edge, `res_p` and `res_m` keep their values, whatever the other inputs do.
- R9: Take 16-bit a and b, and 15-bit c1 and c2. Feed in accumulators (a+b)*c1 and (a-b)*c1, the operand b, d = c2 - c1 and shift 14. The results are then floor((a*c1 + b*c2 + 8192) / 16384) and floor((a*c1 - b*c2 + 8192) / 16384).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture a new result this edge |
| acc_p | input | XLEN | Plus-lane accumulator (signed) |
| acc_m | input | XLEN | Minus-lane accumulator (signed) |
| mul_b | input | XLEN | Multiplier operand b (signed) |
| coef_d | input | XLEN | Coefficient difference d (signed) |
| shamt | input | log2(XLEN)+1 | Rounding shift amount, 0 to 2*XLEN-1 |
| out_valid | output | 1 | Result registered in the previous cycle |
| res_p | output | XLEN | Rounded accumulator plus product |
| res_m | output | XLEN | Rounded accumulator minus product |

## Verification
Each result is due exactly one rising edge after the strobe. The bench drives operands on the falling edge with `in_valid` set. It drops the strobe on the next falling edge and samples `out_valid`, `res_p` and `res_m` at that same falling edge, which is half a period after the capturing edge. The falling edge after that must show `out_valid` low. For the hold check, the inputs are changed with the strobe low, and the outputs are compared one full cycle later against the values they had just before.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

    // Which way the shared product enters a lane.
    typedef enum logic {
        LANE_ADD = 1'b0,
        LANE_SUB = 1'b1
    } lane_op_e;

    // Internal width: double the data width plus one guard bit for the
    // rounding carry.
    function automatic int unsigned ext_width(input int unsigned xlen);
        return 2 * xlen + 1;
    endfunction

endpackage

// File: rtl/bfly_prod.sv
module bfly_prod #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned PW = 2 * XLEN
) (
    input  logic [XLEN-1:0] op_b,
    input  logic [XLEN-1:0] op_d,
    output logic [PW-1:0]   prod
);
    logic signed [PW-1:0] ext_b;
    logic signed [PW-1:0] ext_d;

    always_comb begin
        ext_b = {{XLEN{op_b[XLEN-1]}}, op_b};
        ext_d = {{XLEN{op_d[XLEN-1]}}, op_d};
        prod  = ext_b * ext_d;
    end
endmodule

// File: rtl/bfly_rndshift.sv
module bfly_rndshift #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned EW  = bfly_pkg::ext_width(XLEN),
    localparam int unsigned SHW = $clog2(XLEN) + 1
) (
    input  logic [EW-1:0]   sum_in,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);
    logic [EW-1:0]        rnd;
    logic signed [EW-1:0] rounded;

    always_comb begin
        if (shamt == '0) begin
            rnd = '0;
        end else begin
            rnd = EW'(1) << (shamt - 1'b1);
        end
        rounded = $signed(sum_in + rnd);
        // The arithmetic shift replicates the sign into every window bit
        // whose source lies above the extended sum.
        res = XLEN'(rounded >>> shamt);
    end
endmodule

// File: rtl/bfly_lane.sv
module bfly_lane #(
    parameter int unsigned XLEN = 32,
    parameter bfly_pkg::lane_op_e OP = bfly_pkg::LANE_ADD,
    localparam int unsigned EW  = bfly_pkg::ext_width(XLEN),
    localparam int unsigned PW  = 2 * XLEN,
    localparam int unsigned SHW = $clog2(XLEN) + 1
) (
    input  logic [XLEN-1:0] acc,
    input  logic [PW-1:0]   prod,
    input  logic [SHW-1:0]  shamt,
    output logic [XLEN-1:0] res
);
    logic [EW-1:0] acc_x;
    logic [EW-1:0] prod_x;
    logic [EW-1:0] sum;

    always_comb begin
        acc_x  = {{(EW - XLEN){acc[XLEN-1]}}, acc};
        prod_x = {prod[PW-1], prod};
    end

    generate
        if (OP == bfly_pkg::LANE_SUB) begin : g_sub
            always_comb sum = acc_x - prod_x;
        end else begin : g_add
            always_comb sum = acc_x + prod_x;
        end
    endgenerate

    bfly_rndshift #(.XLEN(XLEN)) u_rs (
        .sum_in (sum),
        .shamt  (shamt),
        .res    (res)
    );
endmodule

// File: rtl/bfly_mac_rs.sv
module bfly_mac_rs #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned PW  = 2 * XLEN,
    localparam int unsigned SHW = $clog2(XLEN) + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [XLEN-1:0] acc_p,
    input  logic [XLEN-1:0] acc_m,
    input  logic [XLEN-1:0] mul_b,
    input  logic [XLEN-1:0] coef_d,
    input  logic [SHW-1:0]  shamt,
    output logic            out_valid,
    output logic [XLEN-1:0] res_p,
    output logic [XLEN-1:0] res_m
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] plus;
        logic [XLEN-1:0] minus;
    } out_reg_t;

    logic [PW-1:0]   prod;
    logic [XLEN-1:0] lane_acc [2];
    logic [XLEN-1:0] lane_res [2];
    out_reg_t        q;

    bfly_prod #(.XLEN(XLEN)) u_prod (
        .op_b (mul_b),
        .op_d (coef_d),
        .prod (prod)
    );

    assign lane_acc[0] = acc_p;
    assign lane_acc[1] = acc_m;

    generate
        for (genvar g = 0; g < 2; g++) begin : g_lane
            if (g == 0) begin : g_plus
                bfly_lane #(.XLEN(XLEN), .OP(bfly_pkg::LANE_ADD)) u_lane (
                    .acc   (lane_acc[g]),
                    .prod  (prod),
                    .shamt (shamt),
                    .res   (lane_res[g])
                );
            end else begin : g_minus
                bfly_lane #(.XLEN(XLEN), .OP(bfly_pkg::LANE_SUB)) u_lane (
                    .acc   (lane_acc[g]),
                    .prod  (prod),
                    .shamt (shamt),
                    .res   (lane_res[g])
                );
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q.vld <= in_valid;
            if (in_valid) begin
                q.plus  <= lane_res[0];
                q.minus <= lane_res[1];
            end
        end
    end

    assign out_valid = q.vld;
    assign res_p     = q.plus;
    assign res_m     = q.minus;
endmodule

// File: rtl/bfly_mac_rs_chk.sv
module bfly_mac_rs_chk #(
    parameter int unsigned XLEN = 32,
    localparam int unsigned SHW = $clog2(XLEN) + 1
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [XLEN-1:0] acc_p,
    input logic [XLEN-1:0] acc_m,
    input logic [XLEN-1:0] mul_b,
    input logic [XLEN-1:0] coef_d,
    input logic [SHW-1:0]  shamt,
    input logic            out_valid,
    input logic [XLEN-1:0] res_p,
    input logic [XLEN-1:0] res_m
);
    logic [XLEN-1:0] low_prod;
    logic [XLEN-1:0] zero_p;
    logic [XLEN-1:0] zero_m;

    assign low_prod = mul_b * coef_d;
    assign zero_p   = acc_p + low_prod;
    assign zero_m   = acc_m - low_prod;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!out_valid && res_p == '0 && res_m == '0)); // R1

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R2

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R2

    AST_ZERO_SHIFT_PLUS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt == '0) |=> res_p == $past(zero_p)); // R5

    AST_ZERO_SHIFT_MINUS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && shamt == '0) |=> res_m == $past(zero_m)); // R5

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_p) && $stable(res_m))); // R8
endmodule

bind bfly_mac_rs bfly_mac_rs_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/bfly_mac_rs_tb.sv
module bfly_mac_rs_tb;
    localparam int XLEN = 32;
    localparam int SHW  = 6;
    localparam int NVEC = 7;

    typedef struct packed {
        logic [31:0]    ap;
        logic [31:0]    am;
        logic [31:0]    b;
        logic [31:0]    d;
        logic [SHW-1:0] s;
        logic [31:0]    ep;
        logic [31:0]    em;
    } vec_t;

    // Stimulus and expected results (R3 plus lane, R4 minus lane).
    localparam vec_t VEC [NVEC] = '{
        '{32'd100, 32'hFFFFFF9C, 32'd3, 32'd5, 6'd0, 32'd115, 32'hFFFFFF8D},
        '{32'd3, 32'hFFFFFFFD, 32'd0, 32'd0, 6'd1, 32'd2, 32'hFFFFFFFF},
        '{32'd0, 32'd0, 32'h80000000, 32'h7FFFFFFF, 6'd40, 32'hFFC00000, 32'h00400000},
        '{32'd5, 32'd5, 32'd7, 32'hFFFFFFFD, 6'd0, 32'hFFFFFFF0, 32'd26},
        '{32'd0, 32'd0, 32'h80000000, 32'h80000000, 6'd63, 32'd1, 32'd0},
        '{32'h7FFFFFFF, 32'h80000000, 32'd1, 32'd1, 6'd1, 32'h40000000, 32'hC0000000},
        '{32'hFFFFFFF9, 32'd9, 32'hFFFFFFFC, 32'd6, 6'd2, 32'hFFFFFFF8, 32'd8}
    };

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_valid = 1'b0;
    logic [XLEN-1:0] acc_p = '0;
    logic [XLEN-1:0] acc_m = '0;
    logic [XLEN-1:0] mul_b = '0;
    logic [XLEN-1:0] coef_d = '0;
    logic [SHW-1:0]  shamt = '0;
    logic            out_valid;
    logic [XLEN-1:0] res_p;
    logic [XLEN-1:0] res_m;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bfly_mac_rs #(.XLEN(XLEN)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .acc_p(acc_p), .acc_m(acc_m), .mul_b(mul_b), .coef_d(coef_d),
        .shamt(shamt), .out_valid(out_valid), .res_p(res_p), .res_m(res_m)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    endtask

    // Drive one strobe; on return the registered result is visible.
    task automatic issue(input logic [31:0] ap, input logic [31:0] am,
                         input logic [31:0] b, input logic [31:0] d,
                         input logic [SHW-1:0] s);
        @(negedge clk);
        acc_p = ap; acc_m = am; mul_b = b; coef_d = d; shamt = s;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] hold_p;
        logic [31:0] hold_m;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", {31'd0, out_valid}, 32'd0);
        chk("R1 res_p in reset", res_p, 32'd0);
        chk("R1 res_m in reset", res_m, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            issue(VEC[i].ap, VEC[i].am, VEC[i].b, VEC[i].d, VEC[i].s);
            chk("R2 out_valid after strobe", {31'd0, out_valid}, 32'd1);
            chk("R3 res_p table", res_p, VEC[i].ep);
            chk("R4 res_m table", res_m, VEC[i].em);
        end

        // Directed corner cases.
        issue(32'd5, 32'd5, 32'd7, 32'hFFFFFFFD, 6'd0);
        chk("R5 zero shift plus", res_p, 32'hFFFFFFF0);
        chk("R5 zero shift minus", res_m, 32'd26);
        issue(32'd3, 32'hFFFFFFFD, 32'd0, 32'd0, 6'd1);
        chk("R6 half up positive", res_p, 32'd2);
        chk("R6 half up negative", res_m, 32'hFFFFFFFF);
        issue(32'd0, 32'd0, 32'h80000000, 32'h7FFFFFFF, 6'd40);
        chk("R7 sign fill plus", res_p, 32'hFFC00000);
        chk("R7 sign fill minus", res_m, 32'h00400000);

        @(negedge clk);
        chk("R2 out_valid drops", {31'd0, out_valid}, 32'd0);

        // Hold: new operands without a strobe leave the results untouched.
        hold_p = res_p;
        hold_m = res_m;
        acc_p = 32'h11111111; acc_m = 32'h22222222;
        mul_b = 32'd9; coef_d = 32'd9; shamt = 6'd3;
        @(negedge clk);
        @(negedge clk);
        chk("R8 res_p held", res_p, hold_p);
        chk("R8 res_m held", res_m, hold_m);

        // Two-step coefficient butterfly with random 16-bit data.
        for (int k = 0; k < 40; k++) begin
            logic signed [15:0] ra;
            logic signed [15:0] rb;
            logic signed [14:0] rc1;
            logic signed [14:0] rc2;
            longint a, b, c1, c2, tp, tm, ep, em;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc1 = 15'($urandom);
            rc2 = 15'($urandom);
            a = ra; b = rb; c1 = rc1; c2 = rc2;
            tp = (a + b) * c1;
            tm = (a - b) * c1;
            ep = (a * c1 + b * c2 + 8192) >>> 14;
            em = (a * c1 - b * c2 + 8192) >>> 14;
            issue(32'(tp), 32'(tm), 32'(b), 32'(c2 - c1), 6'd14);
            chk("R9 two-step plus", res_p, 32'(ep));
            chk("R9 two-step minus", res_m, 32'(em));
        end

        // Reset in mid-run clears the registered results.
        issue(32'd1000, 32'd2000, 32'd3, 32'd4, 6'd0);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 res_p after reset", res_p, 32'd0);
        chk("R1 res_m after reset", res_m, 32'd0);
        chk("R1 out_valid after reset", {31'd0, out_valid}, 32'd0);
        rst = 1'b0;

        finish_run();
    end
endmodule